// File: doc/BRIEF.md
# DDC1/DDC2B Display ID Transmitter

This block sends a monitor's display identification bytes to a host over the display data channel. Software loads bytes into an eight-entry transmit queue through a valid/ready write port. While the block is in the clocked-by-vertical-sync mode (DDC1), each rising edge of the vertical sync input shifts one bit onto the data line. Each byte goes out as a 9-bit packet: eight data bits, MSB first, followed by a separator bit that is always 1. When the queue is empty, the data line idles high.

The block watches the host clock line. A falling edge on it moves the block into the bidirectional bus mode (DDC2B). There the data line is released high and the queue is left untouched. If the host clock then stays high for `TIMEOUT_VS` vertical sync rising edges, the block falls back to DDC1. Once a valid bus access has been reported on `host_access`, the block stays in DDC2B until software clears the mode flag with `ddc2_clr`. Queue level flags and a maskable low-level interrupt let software refill the queue in bursts.

Write port rules: a byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the queue holds eight bytes. The writer must then hold `wr_valid` and `wr_data` until `wr_ready` returns. Back-pressure never drops a byte.

Top module: `ddc_id_tx`

## Requirements
- R1: After reset the block is in DDC1 (`ddc2_mode`=0), `sda_drive`=1, `fifo_low`=1, `fifo_high`=0, `fifo_irq`=0 and `wr_ready`=1.
- R2: In DDC1 with the host clock high, each rising edge of `vsync_in` drives the next bit of the current byte onto `sda_drive`, MSB first. The bit appears within three `clk` edges of the edge on the input.
- R3: The ninth bit of every packet is 1. The next queued byte starts on the following rising edge of vertical sync.
- R4: The queue holds 8 bytes. When 8 bytes are queued, `fifo_high`=1 and `wr_ready`=0, and further writes are not taken.
- R5: `fifo_low`=1 when the number of queued bytes is less than `lo_sel`+2. Codes 00, 01, 10 and 11 give thresholds 2, 3, 4 and 5.
- R6: An internal flag is set when `fifo_low` goes from 0 to 1. The flag is cleared by a one-cycle `irq_clr` pulse and is not set again while `fifo_low` stays 1. `fifo_irq` is the flag ANDed with `irq_en`.
- R7: A falling edge on `scl_in` in DDC1 sets `ddc2_mode`=1. In DDC2B `sda_drive`=1 and vertical sync edges take no bytes from the queue.
- R8: In DDC2B without a latched access, `TIMEOUT_VS` vertical sync rising edges with the host clock high return the block to DDC1. A low level on the host clock restarts this count.
- R9: A `host_access` pulse in DDC2B latches the mode, so no number of sync edges returns it to DDC1. A `ddc2_clr` pulse returns the block to DDC1 and drops the latch.
- R10: In DDC1 with an empty queue and no packet in progress, `sda_drive` stays 1 on vertical sync edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Host clock line level (asynchronous) |
| vsync_in | input | 1 | Vertical sync, DDC1 bit clock (asynchronous) |
| wr_valid | input | 1 | Queue write request |
| wr_data | input | 8 | Byte to queue |
| wr_ready | output | 1 | Queue can take a byte |
| lo_sel | input | 2 | Low-level threshold code |
| irq_en | input | 1 | Low-level interrupt enable |
| irq_clr | input | 1 | Pulse: clear low-level interrupt flag |
| ddc2_clr | input | 1 | Pulse: return to DDC1 and drop access latch |
| host_access | input | 1 | Pulse: valid bus access seen by the host-side slave |
| sda_drive | output | 1 | Data line level; 1 releases the line high |
| fifo_low | output | 1 | Queue level below threshold |
| fifo_high | output | 1 | Queue full (more than 7 bytes) |
| fifo_irq | output | 1 | Masked low-level interrupt |
| ddc2_mode | output | 1 | 1 in DDC2B, 0 in DDC1 |

## Verification
The bench builds the block with `TIMEOUT_VS`=8 and a queue depth of 8. The shorter timeout lets the bench reach the exact expiry edge, and a restart of the count after a host clock low, in a few hundred cycles. The depth of 8 lets the bench reach full, the refused write and every threshold code from random fill levels. Random bytes are shifted out bit by bit and compared with a bench-side queue model. Directed sequences cover the interrupt edge, mode entry, the access latch and the software clear.

// File: rtl/ddc_tx_pkg.sv
package ddc_tx_pkg;
  typedef enum logic {
    MODE_DDC1 = 1'b0,
    MODE_DDC2 = 1'b1
  } ddc_mode_e;

  localparam int BYTE_W   = 8;
  localparam int LOW_BASE = 2;
  localparam int PKT_BITS = BYTE_W + 1;
endpackage

// File: rtl/ddc_sync_edge.sv
module ddc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_val,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= rst_val;
      s2 <= rst_val;
      s3 <= rst_val;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
endmodule

// File: rtl/ddc_tx_fifo.sv
module ddc_tx_fifo
  import ddc_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              empty,
  input  logic [1:0]        lo_sel,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              fifo_low,
  output logic              fifo_high,
  output logic              fifo_irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  count;
  logic              push, do_pop;
  logic [CNT_W:0]    thresh;
  logic              low_q, irq_flag;

  assign wr_ready = (count != CNT_W'(DEPTH));
  assign push     = wr_valid & wr_ready;
  assign empty    = (count == '0);
  assign do_pop   = pop & ~empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign thresh    = (CNT_W + 1)'(lo_sel) + (CNT_W + 1)'(LOW_BASE);
  assign fifo_low  = ({1'b0, count} < thresh);
  assign fifo_high = (count > CNT_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= 1'b1;
      irq_flag <= 1'b0;
    end else begin
      low_q <= fifo_low;
      if (fifo_low && !low_q) irq_flag <= 1'b1;
      else if (irq_clr)       irq_flag <= 1'b0;
    end
  end

  assign fifo_irq = irq_flag & irq_en;
endmodule

// File: rtl/ddc1_serializer.sv
module ddc1_serializer
  import ddc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              in_ddc2,
  input  logic              empty,
  input  logic [BYTE_W-1:0] head,
  output logic              pop,
  output logic              sda_out
);
  localparam int POS_W = $clog2(PKT_BITS + 1);

  logic [BYTE_W-1:0] shreg;
  logic [POS_W-1:0]  pos;
  logic              busy, sda_q;

  assign pop = shift_en & ~busy & ~empty & ~in_ddc2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      pos   <= '0;
      busy  <= 1'b0;
      sda_q <= 1'b1;
    end else if (in_ddc2) begin
      busy  <= 1'b0;
      pos   <= '0;
      sda_q <= 1'b1;
    end else if (shift_en) begin
      if (!busy) begin
        if (!empty) begin
          sda_q <= head[BYTE_W-1];
          shreg <= {head[BYTE_W-2:0], 1'b0};
          pos   <= POS_W'(1);
          busy  <= 1'b1;
        end else begin
          sda_q <= 1'b1;
        end
      end else if (pos == POS_W'(BYTE_W)) begin
        sda_q <= 1'b1;
        busy  <= 1'b0;
        pos   <= '0;
      end else begin
        sda_q <= shreg[BYTE_W-1];
        shreg <= {shreg[BYTE_W-2:0], 1'b0};
        pos   <= pos + 1'b1;
      end
    end
  end

  assign sda_out = in_ddc2 ? 1'b1 : sda_q;
endmodule

// File: rtl/ddc_mode_fsm.sv
module ddc_mode_fsm
  import ddc_tx_pkg::*;
#(
  parameter int TIMEOUT_VS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_hi,
  input  logic scl_fall,
  input  logic vs_rise,
  input  logic host_access,
  input  logic ddc2_clr,
  output logic in_ddc2
);
  localparam int TCNT_W = $clog2(TIMEOUT_VS);

  ddc_mode_e         mode;
  logic              locked;
  logic [TCNT_W-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_DDC1;
      locked <= 1'b0;
      tcnt   <= '0;
    end else if (ddc2_clr) begin
      mode   <= MODE_DDC1;
      locked <= 1'b0;
      tcnt   <= '0;
    end else if (mode == MODE_DDC1) begin
      tcnt <= '0;
      if (scl_fall) mode <= MODE_DDC2;
    end else begin
      if (host_access) locked <= 1'b1;
      if (!scl_hi) begin
        tcnt <= '0;
      end else if (vs_rise && !locked && !host_access) begin
        if (tcnt == TCNT_W'(TIMEOUT_VS - 1)) begin
          mode <= MODE_DDC1;
          tcnt <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign in_ddc2 = (mode == MODE_DDC2);
endmodule

// File: rtl/ddc_id_tx.sv
module ddc_id_tx
  import ddc_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TIMEOUT_VS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       vsync_in,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic [1:0] lo_sel,
  input  logic       irq_en,
  input  logic       irq_clr,
  input  logic       ddc2_clr,
  input  logic       host_access,
  output logic       sda_drive,
  output logic       fifo_low,
  output logic       fifo_high,
  output logic       fifo_irq,
  output logic       ddc2_mode
);
  logic scl_hi, scl_rise_unused, scl_fall;
  logic vs_lvl_unused, vs_rise, vs_fall_unused;
  logic pop, empty, in_ddc2;
  logic [BYTE_W-1:0] head;

  ddc_sync_edge u_scl_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .async_in(scl_in),
    .level(scl_hi), .rise(scl_rise_unused), .fall(scl_fall)
  );

  ddc_sync_edge u_vs_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .async_in(vsync_in),
    .level(vs_lvl_unused), .rise(vs_rise), .fall(vs_fall_unused)
  );

  ddc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .pop(pop), .head(head), .empty(empty),
    .lo_sel(lo_sel), .irq_en(irq_en), .irq_clr(irq_clr),
    .fifo_low(fifo_low), .fifo_high(fifo_high), .fifo_irq(fifo_irq)
  );

  ddc1_serializer u_ser (
    .clk(clk), .rst_n(rst_n),
    .shift_en(vs_rise & scl_hi), .in_ddc2(in_ddc2),
    .empty(empty), .head(head), .pop(pop), .sda_out(sda_drive)
  );

  ddc_mode_fsm #(.TIMEOUT_VS(TIMEOUT_VS)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .scl_hi(scl_hi), .scl_fall(scl_fall), .vs_rise(vs_rise),
    .host_access(host_access), .ddc2_clr(ddc2_clr), .in_ddc2(in_ddc2)
  );

  assign ddc2_mode = in_ddc2;
endmodule

// File: rtl/ddc_id_tx_chk.sv
module ddc_id_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic irq_en,
  input logic ddc2_clr,
  input logic sda_drive,
  input logic fifo_low,
  input logic fifo_high,
  input logic fifo_irq,
  input logic ddc2_mode
);
  // R4
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_high |-> !wr_ready);
  // R5
  low_high_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_high |-> !fifo_low);
  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !fifo_irq);
  // R7
  ddc2_line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddc2_mode |-> sda_drive);
  // R9
  clear_returns_ddc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddc2_clr |=> !ddc2_mode);
endmodule

bind ddc_id_tx ddc_id_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .irq_en(irq_en), .ddc2_clr(ddc2_clr), .sda_drive(sda_drive),
  .fifo_low(fifo_low), .fifo_high(fifo_high), .fifo_irq(fifo_irq),
  .ddc2_mode(ddc2_mode)
);

// File: tb/ddc_id_tx_test.sv
`timescale 1ns/1ps
module ddc_id_tx_test;
  localparam int DEPTH = 8;
  localparam int TMO   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, vsync_in = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] lo_sel = 2'b00;
  logic irq_en = 1'b0, irq_clr = 1'b0, ddc2_clr = 1'b0, host_access = 1'b0;
  logic wr_ready, sda_drive, fifo_low, fifo_high, fifo_irq, ddc2_mode;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] q[$];

  always #10 clk = ~clk;

  ddc_id_tx #(.FIFO_DEPTH(DEPTH), .TIMEOUT_VS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .vsync_in(vsync_in),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .lo_sel(lo_sel), .irq_en(irq_en), .irq_clr(irq_clr),
    .ddc2_clr(ddc2_clr), .host_access(host_access),
    .sda_drive(sda_drive), .fifo_low(fifo_low), .fifo_high(fifo_high),
    .fifo_irq(fifo_irq), .ddc2_mode(ddc2_mode)
  );

  function automatic logic exp_low(int cnt, logic [1:0] sel);
    return cnt < (int'(sel) + 2);
  endfunction

  function automatic logic exp_bit(logic [7:0] b, int i);
    return (i < 8) ? b[7-i] : 1'b1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic vs_pulse();
    vsync_in = 1'b1; tick(5);
    vsync_in = 1'b0; tick(5);
  endtask

  task automatic push(logic [7:0] b);
    wr_data = b; wr_valid = 1'b1; tick(1);
    wr_valid = 1'b0; tick(1);
    q.push_back(b);
  endtask

  task automatic shift_byte();
    logic [7:0] b;
    b = q.pop_front();
    for (int i = 0; i < 9; i++) begin
      vs_pulse();
      if (i < 8) chk("R2 data bit", sda_drive, exp_bit(b, i));
      else       chk("R3 separator bit", sda_drive, exp_bit(b, i));
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3); rst_n = 1'b1; tick(2);

    // R1 reset state
    chk("R1 ddc2_mode", ddc2_mode, 0);
    chk("R1 sda_drive", sda_drive, 1);
    chk("R1 fifo_low", fifo_low, 1);
    chk("R1 fifo_high", fifo_high, 0);
    chk("R1 fifo_irq", fifo_irq, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // R10 empty idle
    for (int i = 0; i < 3; i++) begin
      vs_pulse();
      chk("R10 idle high", sda_drive, 1);
    end

    // R4 / R5 random fill with random thresholds
    for (int n = 1; n <= DEPTH; n++) begin
      lo_sel = 2'($urandom_range(0, 3));
      push(8'($urandom));
      chk("R5 low threshold", fifo_low, exp_low(n, lo_sel));
    end
    chk("R4 full high", fifo_high, 1);
    chk("R4 full not ready", wr_ready, 0);
    wr_data = 8'hA5; wr_valid = 1'b1; tick(2); wr_valid = 1'b0; tick(1);
    chk("R4 refused write keeps full", fifo_high, 1);

    // R2 / R3 drain; R4 confirms only 8 bytes were taken
    for (int n = DEPTH - 1; n >= 0; n--) begin
      shift_byte();
      lo_sel = 2'($urandom_range(0, 3)); tick(1);
      chk("R5 low while draining", fifo_low, exp_low(n, lo_sel));
      chk("R4 high while draining", fifo_high, 0);
    end
    vs_pulse();
    chk("R4 refused byte absent / R10 idle", sda_drive, 1);

    // R6 interrupt edge, mask, clear
    lo_sel = 2'b00; irq_en = 1'b1;
    pulse(irq_clr);
    chk("R6 cleared", fifo_irq, 0);
    push(8'h3C); push(8'hC3); push(8'h81);
    chk("R6 not low at 3", fifo_low, 0);
    shift_byte();
    chk("R6 no irq at 2 queued", fifo_irq, 0);
    shift_byte();
    chk("R6 irq on entering low", fifo_irq, 1);
    irq_en = 1'b0; tick(1);
    chk("R6 masked", fifo_irq, 0);
    irq_en = 1'b1; tick(1);
    chk("R6 unmasked", fifo_irq, 1);
    pulse(irq_clr);
    chk("R6 clear pulse", fifo_irq, 0);
    shift_byte();
    chk("R6 no re-set while low", fifo_irq, 0);

    // R7 DDC2 entry, queue kept; R8 timeout and restart
    push(8'h5A); push(8'hF0);
    scl_in = 1'b0; tick(5);
    chk("R7 enter ddc2", ddc2_mode, 1);
    chk("R7 line released", sda_drive, 1);
    scl_in = 1'b1; tick(3);
    for (int i = 0; i < TMO - 1; i++) vs_pulse();
    chk("R8 before timeout", ddc2_mode, 1);
    scl_in = 1'b0; tick(4); scl_in = 1'b1; tick(4);
    for (int i = 0; i < TMO - 1; i++) vs_pulse();
    chk("R8 count restarted by scl low", ddc2_mode, 1);
    vs_pulse();
    chk("R8 timeout back to ddc1", ddc2_mode, 0);
    shift_byte();
    shift_byte();
    chk("R7 queue not drained (2 bytes intact)", fifo_low, 1);

    // R9 access latch and software clear
    scl_in = 1'b0; tick(5); scl_in = 1'b1; tick(3);
    chk("R9 in ddc2", ddc2_mode, 1);
    pulse(host_access);
    for (int i = 0; i < 3 * TMO; i++) vs_pulse();
    chk("R9 latched", ddc2_mode, 1);
    pulse(ddc2_clr);
    chk("R9 cleared to ddc1", ddc2_mode, 0);
    scl_in = 1'b0; tick(5); scl_in = 1'b1; tick(3);
    for (int i = 0; i < TMO; i++) vs_pulse();
    chk("R9 latch dropped by clear", ddc2_mode, 0);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      int n;
      n = $urandom_range(1, DEPTH);
      for (int k = 0; k < n; k++) push(8'($urandom));
      chk("R4 high after random fill", fifo_high, (n == DEPTH) ? 1 : 0);
      for (int k = 0; k < n; k++) shift_byte();
      vs_pulse();
      chk("R10 idle after round", sda_drive, 1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule